// File: doc/BRIEF.md
# Floating-Point Operand Unpack Classifier

This block accepts one packed floating-point word per cycle in half, single or double format. The format is chosen by a parameter. The block sorts the word into one of five classes: zero, nonzero finite, infinity, quiet NaN and signalling NaN. Alongside the class it produces a uniform unpacked form: a sign, a two's-complement unbiased exponent and a left-aligned mantissa whose leading one sits at a fixed bit. Arithmetic units further down the pipeline can then work on one common representation, whatever the source format.

Three control inputs shape the decode. The first flushes subnormals to zero for single and double words. The second does the same for half words only. The third selects an alternative half mode that gives up infinities and NaNs in exchange for extended range. A flush of a single or double subnormal raises an input-denormal pulse. All results appear one clock after the input is marked valid.

Top module: `fp_unpack_classify`

## Requirements
- R1: Outputs are registered. `out_valid` equals `in_valid` from the previous cycle. The class, sign, exponent and mantissa outputs load only on a cycle with `in_valid` high and otherwise hold their value. `out_denorm_exc` is high only in the cycle after a valid input that raised it.
- R2: `out_class` is one-hot when `out_valid` is high. Bit 0 means zero, bit 1 nonzero, bit 2 infinity, bit 3 quiet NaN and bit 4 signalling NaN.
- R3: A word whose exponent field and fraction are both zero is classed as zero, with exponent 0 and mantissa 0.
- R4: For single and double, a zero exponent field with a nonzero fraction is classed as zero, with exponent 0 and mantissa 0, when `ftz_wide` is high, and `out_denorm_exc` is raised. `ftz_wide` has no effect on half words.
- R5: For half, a zero exponent field with a nonzero fraction is classed as zero when `ftz_half` is high, and `out_denorm_exc` stays low. `ftz_half` has no effect on single or double words.
- R6: An unflushed subnormal is classed as nonzero. Its highest set fraction bit is moved to mantissa bit 62. Its exponent is (1 - bias - fraction width) plus the index of that highest set bit.
- R7: A normal word is classed as nonzero with exponent (field - bias). The mantissa is the implicit one followed by the fraction, with the implicit one at bit 62 and bit 63 clear. Biases are 15, 127 and 1023, and the fraction widths are 10, 23 and 52.
- R8: An all-ones exponent field with a zero fraction is classed as infinity, with exponent 0 and mantissa 0.
- R9: An all-ones exponent field with a nonzero fraction is a quiet NaN when the top fraction bit is 1 and a signalling NaN otherwise. The exponent and mantissa are 0.
- R10: For half words with `alt_half` high, an all-ones exponent field is decoded as a normal number (exponent +16). `alt_half` has no effect on single or double words.
- R11: `out_sign` equals the top bit of the input word in every class.
- R12: After reset `out_valid`, `out_class`, `out_denorm_exc`, `out_exp` and `out_mant` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word is valid this cycle |
| in_word | input | FMT_BITS | Packed floating-point word |
| ftz_wide | input | 1 | Flush subnormals to zero for single and double |
| ftz_half | input | 1 | Flush subnormals to zero for half |
| alt_half | input | 1 | Alternative half mode: all-ones exponent is a normal number |
| out_valid | output | 1 | Result valid |
| out_class | output | 5 | One-hot class |
| out_sign | output | 1 | Sign |
| out_exp | output | EXP_OUT_W | Unbiased exponent, two's complement |
| out_mant | output | MANT_OUT_W | Left-aligned mantissa, leading one at bit MANT_OUT_W-2 |
| out_denorm_exc | output | 1 | Input-denormal exception pulse |

## Verification
The bench builds three instances side by side with FMT_BITS set to 16, 32 and 64. The exponent and mantissa output widths keep their defaults. All three share the control inputs, so each control is seen both where it acts and where it must be ignored. The half instance brings the half flush and alternative-half paths into reach. The double instance exercises the longest normalization shift and the most negative subnormal exponent, which is -1074.

// File: rtl/fp_unpack_classify.sv
module fp_unpack_classify #(
  parameter int FMT_BITS   = 32,
  parameter int EXP_OUT_W  = 16,
  parameter int MANT_OUT_W = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [FMT_BITS-1:0]   in_word,
  input  logic                  ftz_wide,
  input  logic                  ftz_half,
  input  logic                  alt_half,
  output logic                  out_valid,
  output logic [4:0]            out_class,
  output logic                  out_sign,
  output logic [EXP_OUT_W-1:0]  out_exp,
  output logic [MANT_OUT_W-1:0] out_mant,
  output logic                  out_denorm_exc
);
  localparam int EW       = (FMT_BITS == 16) ? 5 : (FMT_BITS == 32) ? 8 : 11;
  localparam int FW       = FMT_BITS - EW - 1;
  localparam int BIAS     = (1 << (EW - 1)) - 1;
  localparam int POINT    = MANT_OUT_W - 2;
  localparam int SUB_BASE = 1 - BIAS - FW;
  localparam bit IS_HALF  = (FMT_BITS == 16);

  localparam logic [4:0] C_ZERO = 5'b00001;
  localparam logic [4:0] C_NZ   = 5'b00010;
  localparam logic [4:0] C_INF  = 5'b00100;
  localparam logic [4:0] C_QNAN = 5'b01000;
  localparam logic [4:0] C_SNAN = 5'b10000;

  logic          sgn;
  logic [EW-1:0] efld;
  logic [FW-1:0] frac;
  assign sgn  = in_word[FMT_BITS-1];
  assign efld = in_word[FMT_BITS-2:FW];
  assign frac = in_word[FW-1:0];

  logic e_zero, e_ones, f_zero, flush, special;
  assign e_zero  = (efld == '0);
  assign e_ones  = (efld == '1);
  assign f_zero  = (frac == '0);
  assign flush   = IS_HALF ? ftz_half : ftz_wide;
  assign special = e_ones && !(IS_HALF && alt_half);

  logic [7:0] lead;
  always_comb begin
    lead = '0;
    for (int i = 0; i < FW; i++)
      if (frac[i]) lead = 8'(i);
  end

  logic [MANT_OUT_W-1:0] mant_sub, mant_nrm;
  logic [EXP_OUT_W-1:0]  exp_sub, exp_nrm;
  assign mant_sub = MANT_OUT_W'(frac) << (POINT - int'(lead));
  assign mant_nrm = MANT_OUT_W'({1'b1, frac}) << (POINT - FW);
  assign exp_sub  = EXP_OUT_W'(SUB_BASE) + EXP_OUT_W'(lead);
  assign exp_nrm  = EXP_OUT_W'(efld) - EXP_OUT_W'(BIAS);

  logic [4:0]            cls_c;
  logic [EXP_OUT_W-1:0]  exp_c;
  logic [MANT_OUT_W-1:0] mant_c;
  logic                  exc_c;

  always_comb begin
    cls_c  = C_NZ;
    exp_c  = exp_nrm;
    mant_c = mant_nrm;
    exc_c  = 1'b0;
    if (e_zero) begin
      if (f_zero || flush) begin
        cls_c  = C_ZERO;
        exp_c  = '0;
        mant_c = '0;
        exc_c  = !IS_HALF && !f_zero;
      end else begin
        exp_c  = exp_sub;
        mant_c = mant_sub;
      end
    end else if (special) begin
      exp_c  = '0;
      mant_c = '0;
      if (f_zero)          cls_c = C_INF;
      else if (frac[FW-1]) cls_c = C_QNAN;
      else                 cls_c = C_SNAN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      out_class      <= '0;
      out_sign       <= 1'b0;
      out_exp        <= '0;
      out_mant       <= '0;
      out_denorm_exc <= 1'b0;
    end else begin
      out_valid      <= in_valid;
      out_denorm_exc <= in_valid && exc_c;
      if (in_valid) begin
        out_class <= cls_c;
        out_sign  <= sgn;
        out_exp   <= exp_c;
        out_mant  <= mant_c;
      end
    end
  end
endmodule

// File: rtl/fp_unpack_classify_chk.sv
module fp_unpack_classify_chk #(
  parameter int FMT_BITS   = 32,
  parameter int EXP_OUT_W  = 16,
  parameter int MANT_OUT_W = 64
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic [FMT_BITS-1:0]   in_word,
  input logic                  ftz_wide,
  input logic                  out_valid,
  input logic [4:0]            out_class,
  input logic                  out_sign,
  input logic [EXP_OUT_W-1:0]  out_exp,
  input logic [MANT_OUT_W-1:0] out_mant,
  input logic                  out_denorm_exc
);
  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r1_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !out_denorm_exc);
  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_class) && $stable(out_mant) && $stable(out_exp));
  a_r2_class_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_class) == 1);
  a_r3_zero_fields: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class[0] |-> out_exp == '0 && out_mant == '0);
  a_r4_exc_on_flush: assert property (@(posedge clk) disable iff (!rst_n)
    out_denorm_exc |-> out_valid && out_class[0] && $past(ftz_wide));
  a_r7_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_class[1] |-> out_mant[MANT_OUT_W-2] && !out_mant[MANT_OUT_W-1]);
  a_r9_special_fields: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_class[2] || out_class[3] || out_class[4]) |-> out_exp == '0 && out_mant == '0);
  a_r11_sign_passes: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_sign == $past(in_word[FMT_BITS-1]));
endmodule

bind fp_unpack_classify fp_unpack_classify_chk #(
  .FMT_BITS(FMT_BITS), .EXP_OUT_W(EXP_OUT_W), .MANT_OUT_W(MANT_OUT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .ftz_wide(ftz_wide), .out_valid(out_valid), .out_class(out_class),
  .out_sign(out_sign), .out_exp(out_exp), .out_mant(out_mant),
  .out_denorm_exc(out_denorm_exc)
);

// File: tb/fp_unpack_classify_tb_top.sv
module fp_unpack_classify_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic ftz_wide = 1'b0, ftz_half = 1'b0, alt_half = 1'b0;
  logic [15:0] wh = '0;
  logic [31:0] ws = '0;
  logic [63:0] wd = '0;

  always #10 clk = ~clk;

  logic        vh, vs, vd, xh, xs, xd, sh, ss, sd;
  logic [4:0]  ch, cs, cd;
  logic [15:0] eh, es, ed;
  logic [63:0] mh, ms, md;

  fp_unpack_classify #(.FMT_BITS(16)) dut_h (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_word(wh), .ftz_wide(ftz_wide), .ftz_half(ftz_half), .alt_half(alt_half),
    .out_valid(vh), .out_class(ch), .out_sign(sh), .out_exp(eh), .out_mant(mh), .out_denorm_exc(xh));
  fp_unpack_classify #(.FMT_BITS(32)) dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_word(ws), .ftz_wide(ftz_wide), .ftz_half(ftz_half), .alt_half(alt_half),
    .out_valid(vs), .out_class(cs), .out_sign(ss), .out_exp(es), .out_mant(ms), .out_denorm_exc(xs));
  fp_unpack_classify #(.FMT_BITS(64)) dut_d (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_word(wd), .ftz_wide(ftz_wide), .ftz_half(ftz_half), .alt_half(alt_half),
    .out_valid(vd), .out_class(cd), .out_sign(sd), .out_exp(ed), .out_mant(md), .out_denorm_exc(xd));

  int n_chk = 0, n_bad = 0;

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic model(input logic [63:0] w, input int ew, input int fw,
                       output logic [4:0] cls, output logic sgn, output logic [15:0] ex,
                       output logic [63:0] mt, output logic exc, output string tag);
    bit half = (ew == 5);
    int bias = (1 << (ew - 1)) - 1;
    logic [63:0] e = (w >> fw) & ((64'd1 << ew) - 1);
    logic [63:0] f = w & ((64'd1 << fw) - 1);
    sgn = w[ew + fw]; exc = 1'b0; ex = '0; mt = '0;
    if (e == 0) begin
      if (f == 0) begin cls = 5'b00001; tag = "R3"; end
      else if (half ? ftz_half : ftz_wide) begin
        cls = 5'b00001; exc = !half; tag = half ? "R5" : "R4";
      end else begin
        int p = 0;
        for (int i = 0; i < fw; i++) if (f[i]) p = i;
        cls = 5'b00010; mt = f << (62 - p); ex = 16'(1 - bias - fw + p); tag = "R6";
      end
    end else if (e == (64'd1 << ew) - 1 && !(half && alt_half)) begin
      if (f == 0) begin cls = 5'b00100; tag = "R8"; end
      else begin cls = f[fw-1] ? 5'b01000 : 5'b10000; tag = "R9"; end
    end else begin
      cls = 5'b00010; ex = 16'(int'(e) - bias);
      mt = ((64'd1 << fw) | f) << (62 - fw);
      tag = (half && alt_half && e == 31) ? "R10" : "R7";
    end
  endtask

  task automatic cmp(input string fn, input logic [63:0] w, input int ew, input int fw,
                     input logic v, input logic [4:0] c, input logic s, input logic [15:0] e,
                     input logic [63:0] m, input logic x);
    logic [4:0] xc; logic xsg; logic [15:0] xe; logic [63:0] xm; logic xx; string tg;
    model(w, ew, fw, xc, xsg, xe, xm, xx, tg);
    n_chk++;
    if (v !== 1'b1 || c !== xc || s !== xsg || e !== xe || m !== xm || x !== xx) begin
      n_bad++;
      $display("FAIL %s (R11/R2) %s w=%h: actual v=%b c=%b s=%b e=%h m=%h x=%b expected v=1 c=%b s=%b e=%h m=%h x=%b",
               tg, fn, w, v, c, s, e, m, x, xc, xsg, xe, xm, xx);
    end
  endtask

  task automatic apply(input logic [15:0] h, input logic [31:0] s, input logic [63:0] d);
    wh = h; ws = s; wd = d; in_valid = 1'b1;
    @(negedge clk);
    cmp("half", 64'(wh), 5, 10, vh, ch, sh, eh, mh, xh);
    cmp("single", 64'(ws), 8, 23, vs, cs, ss, es, ms, xs);
    cmp("double", wd, 11, 52, vd, cd, sd, ed, md, xd);
  endtask

  function automatic logic [63:0] gen(input int ew, input int fw);
    logic [63:0] w = {$urandom, $urandom};
    logic [63:0] fm = (64'd1 << fw) - 1;
    logic [63:0] em = ((64'd1 << ew) - 1) << fw;
    case ($urandom % 4)
      0: ;
      1: w = w & ~em;
      2: w = w | em;
      default: w = (w & ~fm) | (64'd1 << ($urandom % fw));
    endcase
    if ($urandom % 8 == 0) w = w & ~fm;
    return w;
  endfunction

  task automatic check_bit(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check_bit("R12 valid", vh | vs | vd, 1'b0);
    check_bit("R12 class/exp/mant", |{ch, cs, cd, eh, es, ed, mh, ms, md}, 1'b0);
    check_bit("R12 exc", xh | xs | xd, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 8; k++) begin
      {ftz_wide, ftz_half, alt_half} = 3'(k);
      apply(16'h0000, 32'h0000_0000, 64'h0);                                      // R3
      apply(16'h8000, 32'h8000_0000, 64'h8000_0000_0000_0000);                    // R3 R11
      apply(16'h0001, 32'h0000_0001, 64'h0000_0000_0000_0001);                    // R4 R5 R6
      apply(16'h83FF, 32'h807F_FFFF, 64'h800F_FFFF_FFFF_FFFF);                    // R4 R5 R6
      apply(16'h7BFF, 32'h7F7F_FFFF, 64'h7FEF_FFFF_FFFF_FFFF);                    // R7
      apply(16'h0400, 32'h0080_0000, 64'h0010_0000_0000_0000);                    // R7
      apply(16'h7C00, 32'hFF80_0000, 64'h7FF0_0000_0000_0000);                    // R8 R10
      apply(16'hFE00, 32'h7FC0_0000, 64'hFFF8_0000_0000_0000);                    // R9 R10
      apply(16'h7C01, 32'h7F80_0001, 64'h7FF0_0000_0000_0001);                    // R9 R10
      apply(16'hFFFF, 32'h7FFF_FFFF, 64'h7FF7_FFFF_FFFF_FFFF);                    // R9 R10
    end

    for (int n = 0; n < 600; n++) begin
      {ftz_wide, ftz_half, alt_half} = 3'($urandom);
      apply(16'(gen(5, 10)), 32'(gen(8, 23)), gen(11, 52));
    end

    ftz_wide = 1'b1; ftz_half = 1'b0; alt_half = 1'b0;
    apply(16'h7C00, 32'h0000_0005, 64'h3FF0_0000_0000_0000);
    in_valid = 1'b0;
    wh = 16'h0001; ws = 32'h7F80_0000; wd = 64'h0;
    @(negedge clk);
    check_bit("R1 valid drops", vs, 1'b0);
    check_bit("R1 exc clears", xs, 1'b0);
    check_bit("R1 class holds", cs == 5'b00001, 1'b1);
    check_bit("R1 half class holds", ch == 5'b00100, 1'b1);
    check_bit("R1 double exp holds", ed == 16'h0000 && md[62], 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule